// File: doc/BRIEF.md
# Read-Modify-Write Byte Write Controller

This block sits between a requester that writes at byte granularity and a backing store that can only be read or written as complete 64-bit words and has no byte enables. A write that covers only some byte lanes is turned into an internal sequence: the containing word is fetched into a holding register, the selected lanes are replaced, and the whole word is written back to the same word address. A write that covers every lane skips the fetch. A write that covers no lane finishes at once and leaves the memory untouched. Reads always return the whole word.

The requester names the target lanes in one of two ways, chosen per request. In size form it gives a byte count and a starting lane taken from the low address bits. In lane form it gives eight byte-lane enables, and the low address bits are then ignored. Write data is lane-aligned: lane k's byte always travels on bits 8k+7..8k. The backing store answers a read after a fixed latency set by a parameter. The controller accepts one request at a time, so a read that arrives during a read-modify-write waits for the write-back and then sees the new word.

Top module: `rmw_byte_writer`

## Requirements
- R1: Every memory access uses word address req_addr_i[ADDR_W-1:3], and a request changes no memory word other than that one.
- R2: With req_lane_sel_i = 0, size code 0, 1, 2, 3 selects 1, 2, 4, 8 bytes starting at lane req_addr_i[2:0]; lanes that would fall past lane 7 are dropped.
- R3: With req_lane_sel_i = 1, bit k of req_be_i selects lane k and req_addr_i[2:0] has no effect on which lanes change.
- R4: A write selecting some but not all lanes performs exactly one memory read and then one memory write of the merged word; unselected lanes keep the value fetched, and the merge uses the data present exactly RD_LAT cycles after the read strobe.
- R5: A write selecting all eight lanes performs no memory read and one memory write, and req_ready_o is low for 2 cycles after acceptance.
- R6: A write selecting no lane performs no memory access and req_ready_o stays high in the cycle after acceptance.
- R7: A read performs one memory read; rsp_valid_o is high for one cycle, RD_LAT+2 cycles after acceptance, carrying the whole word, and req_ready_o is low for RD_LAT+2 cycles.
- R8: After a partial write is accepted, req_ready_o is low for RD_LAT+3 cycles, including every cycle in which a memory strobe is high.
- R9: A read presented while a read-modify-write is in progress is held off until the write-back completes and returns the updated word.
- R10: mem_re_o and mem_we_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 64 | Lane-aligned write data |
| req_lane_sel_i | input | 1 | 1 = lanes from req_be_i, 0 = lanes from size and offset |
| req_size_i | input | 2 | Byte-count code for size form |
| req_be_i | input | 8 | Byte-lane enables for lane form |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 64 | Read data |
| mem_addr_o | output | ADDR_W-3 | Word address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 64 | Word written to memory |
| mem_rdata_i | input | 64 | Word read from memory, valid RD_LAT cycles after mem_re_o |

## Verification
The bench builds the controller with ADDR_W = 10 and RD_LAT = 3, so the backing model holds 128 words and random addresses are confined to sixteen of them, making back-to-back hits on the same word frequent. A latency of 3 rather than the default 2 exposes any off-by-one in the wait counter, and the memory model drives a poison pattern on every cycle that does not carry read data, so a merge taken one cycle early or late corrupts the written word visibly.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ISSUE,
    ST_RD_WAIT,
    ST_MERGE_WR,
    ST_DONE
  } rmw_state_e;
endpackage

// File: rtl/rmw_lane_decode.sv
module rmw_lane_decode #(
  parameter int LANES  = 8,
  parameter int OFS_W  = $clog2(LANES),
  parameter int SIZE_W = $clog2(OFS_W + 1)
) (
  input  logic              lane_sel_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [LANES-1:0]  be_i,
  output logic [LANES-1:0]  mask_o
);
  logic [2*LANES-1:0] span;
  logic [2*LANES-1:0] shifted;

  always_comb begin
    span = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < (32'd1 << size_i)) span[k] = 1'b1;
    end
    // lanes pushed past the top of the word are discarded
    shifted = span << ofs_i;
    mask_o  = lane_sel_i ? be_i : shifted[LANES-1:0];
  end
endmodule

// File: rtl/rmw_lane_merge.sv
module rmw_lane_merge #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] old_i,
  input  logic [LANES*LANE_W-1:0] new_i,
  input  logic [LANES-1:0]        mask_i,
  output logic [LANES*LANE_W-1:0] word_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_o[g*LANE_W +: LANE_W] = mask_i[g] ? new_i[g*LANE_W +: LANE_W]
                                                  : old_i[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/rmw_lat_timer.sv
module rmw_lat_timer #(
  parameter int LAT   = 2,
  parameter int CNT_W = $clog2(LAT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(1);
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(LAT)) busy_q <= 1'b0;
      else                      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign expired_o = busy_q && (cnt_q == CNT_W'(LAT));
endmodule

// File: rtl/rmw_byte_writer.sv
module rmw_byte_writer #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 64,
  parameter int RD_LAT  = 2,
  localparam int LANES   = DATA_W / 8,
  localparam int OFS_W   = $clog2(LANES),
  localparam int WADDR_W = ADDR_W - OFS_W,
  localparam int SIZE_W  = $clog2(OFS_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_we_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  input  logic               req_lane_sel_i,
  input  logic [SIZE_W-1:0]  req_size_i,
  input  logic [LANES-1:0]   req_be_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_rdata_o,
  output logic [WADDR_W-1:0] mem_addr_o,
  output logic               mem_re_o,
  output logic               mem_we_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i
);
  import rmw_pkg::*;

  rmw_state_e         state_q, state_d;
  logic [WADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  hold_q;
  logic [LANES-1:0]   mask_q;
  logic               we_q;

  logic [LANES-1:0]   req_mask;
  logic [DATA_W-1:0]  merged;
  logic               accept;
  logic               mask_full;
  logic               mask_empty;
  logic               lat_done;

  rmw_lane_decode #(
    .LANES (LANES),
    .OFS_W (OFS_W),
    .SIZE_W(SIZE_W)
  ) u_decode (
    .lane_sel_i(req_lane_sel_i),
    .size_i    (req_size_i),
    .ofs_i     (req_addr_i[OFS_W-1:0]),
    .be_i      (req_be_i),
    .mask_o    (req_mask)
  );

  rmw_lane_merge #(
    .LANES (LANES),
    .LANE_W(8)
  ) u_merge (
    .old_i (mem_rdata_i),
    .new_i (wdata_q),
    .mask_i(mask_q),
    .word_o(merged)
  );

  rmw_lat_timer #(
    .LAT(RD_LAT)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (state_q == ST_RD_ISSUE),
    .expired_o(lat_done)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign mask_full   = &req_mask;
  assign mask_empty  = ~|req_mask;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (!req_we_i)      state_d = ST_RD_ISSUE;
          else if (mask_empty) state_d = ST_IDLE;
          else if (mask_full)  state_d = ST_MERGE_WR;
          else                 state_d = ST_RD_ISSUE;
        end
      end
      ST_RD_ISSUE: state_d = ST_RD_WAIT;
      ST_RD_WAIT:  if (lat_done) state_d = we_q ? ST_MERGE_WR : ST_DONE;
      ST_MERGE_WR: state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      hold_q  <= '0;
      mask_q  <= '0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept && !(req_we_i && mask_empty)) begin
        addr_q  <= req_addr_i[ADDR_W-1:OFS_W];
        wdata_q <= req_wdata_i;
        hold_q  <= req_wdata_i;
        mask_q  <= req_we_i ? req_mask : '0;
        we_q    <= req_we_i;
      end else if (state_q == ST_RD_WAIT && lat_done) begin
        // reads carry an empty mask, so the fetched word passes unchanged
        hold_q <= merged;
      end
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_re_o    = (state_q == ST_RD_ISSUE);
  assign mem_we_o    = (state_q == ST_MERGE_WR);
  assign mem_wdata_o = hold_q;
  assign rsp_valid_o = (state_q == ST_DONE) && !we_q;
  assign rsp_rdata_o = hold_q;
endmodule

// File: rtl/rmw_byte_writer_chk.sv
module rmw_byte_writer_chk #(
  parameter int LANES = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             req_we_i,
  input logic             req_lane_sel_i,
  input logic [LANES-1:0] req_be_i,
  input logic             rsp_valid_o,
  input logic             mem_re_o,
  input logic             mem_we_o
);
  logic acc_wr_lane;
  assign acc_wr_lane = req_valid_i && req_ready_o && req_we_i && req_lane_sel_i;

  p_no_overlap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  p_wr_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> !req_ready_o);

  p_full_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr_lane && (&req_be_i)) |=> (mem_we_o && !mem_re_o));

  p_empty_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr_lane && !(|req_be_i)) |=> (req_ready_o && !mem_re_o && !mem_we_o));

  p_part_rd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr_lane && (|req_be_i) && !(&req_be_i)) |=> mem_re_o);

  p_single_rd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> (!mem_re_o && !mem_we_o));

  p_rd_issue_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_we_i) |=> mem_re_o);

  p_rsp_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (req_ready_o && !rsp_valid_o));
endmodule

bind rmw_byte_writer rmw_byte_writer_chk #(
  .LANES(LANES)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .req_we_i      (req_we_i),
  .req_lane_sel_i(req_lane_sel_i),
  .req_be_i      (req_be_i),
  .rsp_valid_o   (rsp_valid_o),
  .mem_re_o      (mem_re_o),
  .mem_we_o      (mem_we_o)
);

// File: tb/rmw_byte_writer_tb.sv
`timescale 1ns/1ps
module rmw_byte_writer_tb;
  localparam int ADDR_W  = 10;
  localparam int RD_LAT  = 3;
  localparam int WADDR_W = ADDR_W - 3;
  localparam int WORDS   = 1 << WADDR_W;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic               req_we = 1'b0;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic [63:0]        req_wdata = '0;
  logic               req_lane_sel = 1'b0;
  logic [1:0]         req_size = '0;
  logic [7:0]         req_be = '0;
  logic               rsp_valid;
  logic [63:0]        rsp_rdata;
  logic [WADDR_W-1:0] mem_addr;
  logic               mem_re;
  logic               mem_we;
  logic [63:0]        mem_wdata;
  logic [63:0]        mem_rdata;

  int checks = 0;
  int errors = 0;
  int cnt_re = 0;
  int cnt_we = 0;
  int cnt_both = 0;
  bit finished = 0;

  logic [63:0] mem_q  [WORDS];
  logic [63:0] pipe   [RD_LAT];
  logic [63:0] shadow [WORDS];

  always #2.5 clk = ~clk;

  rmw_byte_writer #(
    .ADDR_W(ADDR_W),
    .DATA_W(64),
    .RD_LAT(RD_LAT)
  ) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .req_valid_i   (req_valid),
    .req_ready_o   (req_ready),
    .req_we_i      (req_we),
    .req_addr_i    (req_addr),
    .req_wdata_i   (req_wdata),
    .req_lane_sel_i(req_lane_sel),
    .req_size_i    (req_size),
    .req_be_i      (req_be),
    .rsp_valid_o   (rsp_valid),
    .rsp_rdata_o   (rsp_rdata),
    .mem_addr_o    (mem_addr),
    .mem_re_o      (mem_re),
    .mem_we_o      (mem_we),
    .mem_wdata_o   (mem_wdata),
    .mem_rdata_i   (mem_rdata)
  );

  function automatic logic [63:0] init_word(int i);
    return {8'hA5, 8'(i), 16'h1234, 8'(i * 3), 8'h5A, 16'(i * 77)};
  endfunction

  // word-only memory with fixed read latency; poison on idle cycles
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= init_word(i);
      for (int k = 0; k < RD_LAT; k++) pipe[k] <= 64'hBAD0_BAD0_BAD0_BAD0;
    end else begin
      if (mem_we) mem_q[mem_addr] <= mem_wdata;
      pipe[0] <= mem_re ? mem_q[mem_addr] : 64'hBAD0_BAD0_BAD0_BAD0;
      for (int k = 1; k < RD_LAT; k++) pipe[k] <= pipe[k-1];
      if (mem_re) cnt_re <= cnt_re + 1;
      if (mem_we) cnt_we <= cnt_we + 1;
      if (mem_re && mem_we) cnt_both <= cnt_both + 1;
    end
  end
  assign mem_rdata = pipe[RD_LAT-1];

  function automatic logic [7:0] exp_mask(logic lsel, logic [1:0] sz, logic [2:0] ofs,
                                          logic [7:0] be);
    logic [7:0] m = '0;
    int n = 1 << sz;
    if (lsel) return be;
    for (int k = 0; k < 8; k++) if (k >= int'(ofs) && k < int'(ofs) + n) m[k] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] exp_merge(logic [63:0] old_w, logic [63:0] new_w,
                                            logic [7:0] m);
    logic [63:0] r = old_w;
    for (int k = 0; k < 8; k++) if (m[k]) r[8*k +: 8] = new_w[8*k +: 8];
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_req(logic we, logic lsel, logic [1:0] sz, logic [ADDR_W-1:0] a,
                         logic [63:0] wd, logic [7:0] be);
    logic [7:0]  m = exp_mask(lsel, sz, a[2:0], be);
    int          wa = int'(a[ADDR_W-1:3]);
    int          e_re, e_we, e_busy, busy, rsp_at, re0, we0;
    logic [63:0] rsp_d = '0;
    string       tag;
    if (!we)           begin e_re = 1; e_we = 0; e_busy = RD_LAT + 2; tag = "R7"; end
    else if (m == 0)   begin e_re = 0; e_we = 0; e_busy = 0;          tag = "R6"; end
    else if (&m)       begin e_re = 0; e_we = 1; e_busy = 2;          tag = "R5"; end
    else               begin e_re = 1; e_we = 1; e_busy = RD_LAT + 3; tag = "R8"; end
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_lane_sel = lsel; req_size = sz;
    req_addr = a; req_wdata = wd; req_be = be;
    while (!req_ready) @(negedge clk);
    re0 = cnt_re; we0 = cnt_we;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0; rsp_at = -1;
    for (int k = 1; !req_ready; k++) begin
      if (rsp_valid) begin rsp_at = k; rsp_d = rsp_rdata; end
      busy++;
      @(negedge clk);
    end
    chk(busy == e_busy, tag, "busy cycles", 64'(busy), 64'(e_busy));
    chk(cnt_re - re0 == e_re, we ? "R4" : "R7", "read count", 64'(cnt_re - re0), 64'(e_re));
    chk(cnt_we - we0 == e_we, "R4", "write count", 64'(cnt_we - we0), 64'(e_we));
    if (we) shadow[wa] = exp_merge(shadow[wa], wd, m);
    if (!we) begin
      chk(rsp_at == RD_LAT + 2, "R7", "rsp cycle", 64'(rsp_at), 64'(RD_LAT + 2));
      chk(rsp_d == shadow[wa], "R7", "rsp data", rsp_d, shadow[wa]);
    end else begin
      chk(mem_q[wa] == shadow[wa], lsel ? "R3" : "R2", "memory word", mem_q[wa], shadow[wa]);
    end
  endtask

  // partial write followed at once by a read of the same word (R9)
  task automatic stall_case(logic [ADDR_W-1:0] a, logic [63:0] wd, logic [7:0] be);
    int wa = int'(a[ADDR_W-1:3]);
    int re0, waited;
    logic [63:0] got = '0;
    bit seen = 0;
    @(negedge clk);
    re0 = cnt_re;
    req_valid = 1'b1; req_we = 1'b1; req_lane_sel = 1'b1; req_addr = a;
    req_wdata = wd; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_we = 1'b0;
    shadow[wa] = exp_merge(shadow[wa], wd, be);
    waited = 0;
    while (!req_ready) begin waited++; @(negedge clk); end
    chk(waited == RD_LAT + 3, "R9", "read hold-off", 64'(waited), 64'(RD_LAT + 3));
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) begin
      if (rsp_valid) begin got = rsp_rdata; seen = 1; end
      @(negedge clk);
    end
    chk(seen && got == shadow[wa], "R9", "read after rmw", got, shadow[wa]);
    chk(cnt_re - re0 == 2, "R9", "reads in stall case", 64'(cnt_re - re0), 64'd2);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) shadow[i] = init_word(i);
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_re && !mem_we && !rsp_valid, "R6", "reset state",
        {60'd0, req_ready, mem_re, mem_we, rsp_valid}, 64'h8);

    // directed corners
    run_req(1'b0, 1'b0, 2'd0, 10'h028, '0, 8'h00);                        // R7 read
    run_req(1'b1, 1'b0, 2'd0, 10'h02D, 64'h0000_EE00_0000_0000, 8'h00);   // R2 byte at lane 5
    run_req(1'b1, 1'b0, 2'd2, 10'h036, 64'h1122_3344_5566_7788, 8'h00);   // R2 truncated at lane 7
    run_req(1'b1, 1'b0, 2'd1, 10'h041, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);   // R2 two bytes
    run_req(1'b1, 1'b0, 2'd3, 10'h048, 64'hDEAD_BEEF_CAFE_F00D, 8'h00);   // R5 full via size
    run_req(1'b1, 1'b1, 2'd0, 10'h053, 64'hAB00_0000_0000_00CD, 8'h81);   // R3 offset ignored
    run_req(1'b1, 1'b1, 2'd0, 10'h05F, 64'h0123_4567_89AB_CDEF, 8'hFF);   // R5 full via lanes
    run_req(1'b1, 1'b1, 2'd3, 10'h060, 64'h9999_9999_9999_9999, 8'h00);   // R6 empty
    run_req(1'b0, 1'b1, 2'd0, 10'h060, '0, 8'h00);                        // R6 word untouched
    run_req(1'b0, 1'b0, 2'd1, 10'h053, '0, 8'h00);                        // R3 readback
    stall_case(10'h070, 64'h7766_5544_3322_1100, 8'h3C);                  // R9

    // random mix over sixteen words
    for (int n = 0; n < 300; n++) begin
      logic [7:0] be;
      int pick = $urandom_range(0, 9);
      be = (pick == 0) ? 8'hFF : (pick == 1) ? 8'h00 : 8'($urandom);
      run_req(($urandom_range(0, 3) != 0), 1'($urandom), 2'($urandom),
              {3'd0, 4'($urandom), 3'($urandom)},
              {$urandom, $urandom}, be);
      if (n % 50 == 0) stall_case({3'd0, 4'($urandom), 3'd0}, {$urandom, $urandom}, 8'($urandom) | 8'h01 & 8'h7F);
    end

    // R1: no stray word touched anywhere
    begin
      int bad = 0;
      for (int i = 0; i < WORDS; i++) if (mem_q[i] !== shadow[i]) bad++;
      chk(bad == 0, "R1", "words differing from model", 64'(bad), 64'd0);
    end
    chk(cnt_both == 0, "R10", "strobe overlap cycles", 64'(cnt_both), 64'd0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule